// File: doc/BRIEF.md
# Translation Buffer Fill and Demap Controller

This block holds a translation buffer of 64 entries and carries out the three kinds of write that change it. Each entry has a tag word and a translation word. The tag word holds the virtual page with the context in its low 13 bits. The translation word holds a valid flag, a page-size code, a lock flag and the physical page. A fill request picks its own target entry. A direct request names the target entry with address bits. A demap request removes every valid entry whose page covers a given address. For fill and direct requests, the tag word always comes from the tag-access input and the translation word comes from the request data.

The cycle after each request, the block shows which entries changed. When a valid translation is lost, it also sends one flush strobe that carries the base and size of the affected page range, so that caches downstream can drop stale lines. A combinational read port lets the surrounding logic inspect any entry.

Top module: `tlb_fill_ctrl`

## Requirements
- R1: After reset, every tag word and every translation word is zero, `chg_mask` is zero and `flush_valid` is low.
- R2: A fill request (`op_kind` = 0) writes the lowest-indexed entry whose translation word has bit 63 (valid) clear.
- R3: When no entry is invalid, a fill request writes the lowest-indexed entry whose translation word has bit 6 (lock) clear.
- R4: When every entry is valid and locked, a fill request changes no entry and leaves `chg_mask` zero and `flush_valid` low.
- R5: A direct request (`op_kind` = 1) writes the entry whose index is `op_addr[8:3]`, whatever that entry's valid and lock state.
- R6: A fill or direct write stores `tag_access` as the tag word and `op_data` as the translation word.
- R7: A demap request (`op_kind` = 2) zeroes both words of every valid entry where `op_addr` and the tag agree above bit 13+3c. Here c is the entry's size code, taken from translation bits 62:61. Invalid entries and entries that do not match keep their contents.
- R8: When a fill or direct write overwrites a valid entry, `flush_valid` is high for exactly the next cycle. In that cycle `flush_base` is the old tag with the bits below 13+3c cleared, and `flush_size` is 2^(13+3c), where c is the old size code. When the overwritten entry was invalid, no flush is raised.
- R9: When a demap clears at least one entry, `flush_valid` is high for the next cycle with the range of the largest cleared page: `flush_size` is 2^(13+3c) for the largest matching c, and `flush_base` is `op_addr` with the bits below that size cleared. A demap that clears nothing raises no flush.
- R10: In the cycle after a request, `chg_mask` has one bit set for each entry that was written or cleared, and is zero in every other cycle.
- R11: A request with `op_kind` = 3, or with `op_valid` low, changes no entry and raises neither `chg_mask` nor `flush_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_access | input | 64 | Tag word used for fill and direct writes |
| op_valid | input | 1 | Request strobe |
| op_kind | input | 2 | 0 fill, 1 direct, 2 demap, 3 no operation |
| op_addr | input | 64 | Direct index in bits 8:3, or the demap address |
| op_data | input | 64 | Translation word for fill and direct writes |
| rd_idx | input | 6 | Entry index for the read port |
| rd_tag | output | 64 | Tag word of entry `rd_idx` |
| rd_tte | output | 64 | Translation word of entry `rd_idx` |
| chg_mask | output | 64 | Entries changed by the previous request |
| flush_valid | output | 1 | One-cycle flush strobe |
| flush_base | output | 64 | Base address of the range to flush |
| flush_size | output | 64 | Size in bytes of the range to flush |

## Verification
A wrong victim choice shows in `chg_mask` the cycle after the fill. It also shows on the read port, where the entry that should have taken the write still holds its old contents. A mask computed from the wrong size code shows up on a later demap. There, an entry that should have been cleared survives, or a neighbouring entry is cleared, and the read port exposes this at once. A stale or missing flush appears on the flush outputs in the single cycle after the request. For that reason every request is followed by a check of those outputs in that cycle, and by a sweep of all 64 entries against a model kept in the bench.

// File: rtl/tlb_fill_ctrl.sv
module tlb_fill_ctrl #(
  parameter int ENTRIES = 64,
  parameter int W = 64,
  parameter int BASE_SHIFT = 13,
  parameter int VLD_BIT = 63,
  parameter int LCK_BIT = 6,
  parameter int SZ_LSB = 61
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [W-1:0]               tag_access,
  input  logic                       op_valid,
  input  logic [1:0]                 op_kind,
  input  logic [W-1:0]               op_addr,
  input  logic [W-1:0]               op_data,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic [W-1:0]               rd_tag,
  output logic [W-1:0]               rd_tte,
  output logic [ENTRIES-1:0]         chg_mask,
  output logic                       flush_valid,
  output logic [W-1:0]               flush_base,
  output logic [W-1:0]               flush_size
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [1:0] K_FILL = 2'd0, K_DIRECT = 2'd1, K_DEMAP = 2'd2;

  logic [W-1:0] tag_q [ENTRIES];
  logic [W-1:0] tte_q [ENTRIES];

  function automatic logic [W-1:0] pmask(input logic [1:0] code);
    return {W{1'b1}} << (BASE_SHIFT + 3 * int'(code));
  endfunction

  logic [ENTRIES-1:0] hit;
  logic [IW-1:0] free_idx, unl_idx, wr_idx;
  logic free_any, unl_any, hit_any, wr_en;
  logic [1:0] hit_code;

  always_comb begin
    free_idx = '0; free_any = 1'b0;
    unl_idx = '0;  unl_any = 1'b0;
    hit = '0; hit_code = 2'd0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!tte_q[i][VLD_BIT]) begin free_idx = IW'(i); free_any = 1'b1; end
      if (!tte_q[i][LCK_BIT]) begin unl_idx = IW'(i); unl_any = 1'b1; end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      hit[i] = tte_q[i][VLD_BIT] &&
               ((op_addr & pmask(tte_q[i][SZ_LSB+:2])) == (tag_q[i] & pmask(tte_q[i][SZ_LSB+:2])));
      if (hit[i] && tte_q[i][SZ_LSB+:2] > hit_code) hit_code = tte_q[i][SZ_LSB+:2];
    end
  end

  assign hit_any = |hit;
  assign wr_idx = (op_kind == K_DIRECT) ? op_addr[IW+2:3] : (free_any ? free_idx : unl_idx);
  assign wr_en = op_valid && ((op_kind == K_DIRECT) || (op_kind == K_FILL && (free_any || unl_any)));

  wire [W-1:0] old_tag = tag_q[wr_idx];
  wire [W-1:0] old_tte = tte_q[wr_idx];

  assign rd_tag = tag_q[rd_idx];
  assign rd_tte = tte_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end
      chg_mask <= '0;
      flush_valid <= 1'b0;
      flush_base <= '0;
      flush_size <= '0;
    end else begin
      chg_mask <= '0;
      flush_valid <= 1'b0;
      if (wr_en) begin
        tag_q[wr_idx] <= tag_access;
        tte_q[wr_idx] <= op_data;
        chg_mask <= {{(ENTRIES-1){1'b0}}, 1'b1} << wr_idx;
        if (old_tte[VLD_BIT]) begin
          flush_valid <= 1'b1;
          flush_base <= old_tag & pmask(old_tte[SZ_LSB+:2]);
          flush_size <= ~pmask(old_tte[SZ_LSB+:2]) + 1'b1;
        end
      end else if (op_valid && op_kind == K_DEMAP) begin
        for (int i = 0; i < ENTRIES; i++)
          if (hit[i]) begin
            tag_q[i] <= '0;
            tte_q[i] <= '0;
          end
        chg_mask <= hit;
        if (hit_any) begin
          flush_valid <= 1'b1;
          flush_base <= op_addr & pmask(hit_code);
          flush_size <= ~pmask(hit_code) + 1'b1;
        end
      end
    end
  end

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_kind != 2'd3) |=> (chg_mask == '0 && !flush_valid));
  // R8
  flush_has_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> chg_mask != '0);
  // R10
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind != K_DEMAP) |=> $onehot0(chg_mask));
  // R9
  flush_size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> ($countones(flush_size) == 1));
  // R9
  flush_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> ((flush_base & (flush_size - 1'b1)) == '0));
  // R7
  demap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == K_DEMAP) |=> !tte_q[$past(rd_idx)][VLD_BIT] || !chg_mask[$past(rd_idx)]);
endmodule

// File: tb/tlb_fill_ctrl_test.sv
`timescale 1ns/1ps
module tlb_fill_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [63:0] tag_access = 0, op_addr = 0, op_data = 0;
  logic op_valid = 0;
  logic [1:0] op_kind = 0;
  logic [5:0] rd_idx = 0;
  logic [63:0] rd_tag, rd_tte, chg_mask, flush_base, flush_size;
  logic flush_valid;
  int checks = 0, errors = 0;
  logic [63:0] mtag [64];
  logic [63:0] mtte [64];

  always #2 clk = ~clk;

  tlb_fill_ctrl uut (.clk, .rst_n, .tag_access, .op_valid, .op_kind, .op_addr, .op_data,
    .rd_idx, .rd_tag, .rd_tte, .chg_mask, .flush_valid, .flush_base, .flush_size);

  function automatic logic [63:0] msk(input logic [1:0] c);
    logic [63:0] m = 64'hFFFF_FFFF_FFFF_E000;
    for (int k = 0; k < int'(c); k++) m = m << 3;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 64; i++) begin
      rd_idx = 6'(i);
      #0.01;
      chk(rd_tag == mtag[i], {req, " tag"}, rd_tag, mtag[i]);
      chk(rd_tte == mtte[i], {req, " tte"}, rd_tte, mtte[i]);
    end
  endtask

  task automatic do_op(input logic [1:0] kind, input logic [63:0] addr, input logic [63:0] data,
                       input logic [63:0] ta, input string req);
    logic [63:0] e_chg = 0, e_base = 0, e_size = 0;
    logic e_fl = 0;
    int v = -1;
    logic [1:0] big = 0;
    if (kind == 0) begin
      for (int i = 63; i >= 0; i--) if (!mtte[i][6]) v = i;
      for (int i = 63; i >= 0; i--) if (!mtte[i][63]) v = i;
    end else if (kind == 1) v = int'(addr[8:3]);
    if (v >= 0) begin
      e_chg[v] = 1'b1;
      if (mtte[v][63]) begin
        e_fl = 1; e_base = mtag[v] & msk(mtte[v][62:61]); e_size = ~msk(mtte[v][62:61]) + 1;
      end
      mtag[v] = ta; mtte[v] = data;
    end else if (kind == 2) begin
      for (int i = 0; i < 64; i++)
        if (mtte[i][63] && ((addr & msk(mtte[i][62:61])) == (mtag[i] & msk(mtte[i][62:61])))) begin
          e_chg[i] = 1'b1;
          if (mtte[i][62:61] > big) big = mtte[i][62:61];
          mtag[i] = 0; mtte[i] = 0;
        end
      if (e_chg != 0) begin e_fl = 1; e_base = addr & msk(big); e_size = ~msk(big) + 1; end
    end
    @(negedge clk);
    op_valid = 1; op_kind = kind; op_addr = addr; op_data = data; tag_access = ta;
    @(negedge clk);
    op_valid = 0;
    chk(chg_mask == e_chg, {req, " R10 chg_mask"}, chg_mask, e_chg);
    chk(flush_valid == e_fl, {req, " R8/R9 flush_valid"}, 64'(flush_valid), 64'(e_fl));
    if (e_fl) begin
      chk(flush_base == e_base, {req, " R8/R9 flush_base"}, flush_base, e_base);
      chk(flush_size == e_size, {req, " R8/R9 flush_size"}, flush_size, e_size);
    end
    sweep({req, " R6/R7 contents"});
  endtask

  function automatic logic [63:0] mk_tte(input bit vld, input bit lck, input logic [1:0] c);
    return {vld, c, 48'($urandom) , 6'd0, lck, 6'h3} & ~64'h1F80_0000_0000_0000 | {vld, c, 61'd0} | 64'(lck) << 6;
  endfunction

  function automatic logic [63:0] rnd_va();
    logic [63:0] b = 64'h0000_0400_0000_0000 + (64'($urandom_range(0, 3)) << 22);
    return b + (64'($urandom_range(0, 3)) << (13 + 3 * $urandom_range(0, 2))) + 64'($urandom_range(0, 8191));
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin mtag[i] = 0; mtte[i] = 0; end
    repeat (3) @(negedge clk);
    chk(chg_mask == 0, "R1 chg_mask at reset", chg_mask, 0);
    chk(!flush_valid, "R1 flush at reset", 64'(flush_valid), 0);
    sweep("R1 reset contents");
    rst_n = 1;
    do_op(0, 0, mk_tte(1, 0, 2'd0), 64'h0000_0400_0000_2005, "R2 fill empty picks 0");
    do_op(0, 0, mk_tte(1, 1, 2'd3), 64'h0000_0400_0040_0011, "R2 fill next invalid");
    do_op(1, 64'd5 << 3, mk_tte(1, 1, 2'd1), 64'h0000_0400_0001_0003, "R5 direct index 5");
    do_op(0, 0, mk_tte(1, 0, 2'd0), 64'h0000_0400_0000_4000, "R2 fill skips 5 to 2");
    do_op(2, 64'h0000_0400_0040_1234, 0, 0, "R7 demap 4M page");
    do_op(3, 0, mk_tte(1, 0, 0), 64'h1234, "R11 kind 3 ignored");
    for (int i = 0; i < 64; i++)
      do_op(1, 64'(i) << 3, mk_tte(1, 1, 2'(i)), {40'h4, 11'(i), 13'h0}, "R5 lock all");
    do_op(0, 0, mk_tte(1, 0, 0), 64'h9999_0000, "R4 all locked dropped");
    do_op(1, 64'd41 << 3, mk_tte(1, 0, 2'd2), 64'h0000_0400_0010_0000, "R8 direct over valid");
    do_op(0, 0, mk_tte(1, 1, 0), 64'h0000_0400_0020_0001, "R3 fill first unlocked 41");
    do_op(2, 64'h0000_0000_0000_0000, 0, 0, "R9 demap no match");
    for (int n = 0; n < 1500; n++) begin
      int r = $urandom_range(0, 99);
      logic [1:0] k = r < 45 ? 2'd0 : r < 78 ? 2'd1 : r < 95 ? 2'd2 : 2'd3;
      do_op(k, k == 1 ? 64'($urandom) : rnd_va(),
            mk_tte($urandom_range(0, 3) != 0, $urandom_range(0, 9) < 3, 2'($urandom)),
            rnd_va(), "random R2/R3/R5/R7/R8/R9");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule